// File: doc/BRIEF.md
# Burst Transfer Fragmentation Unit

This block sits in front of the command sequencer of a PSRAM-style external memory. It accepts one transfer request at a time: a start byte address, a byte count and the identity of the client that asked for it. It then cuts the transfer into sub-bursts and hands them to the downstream sequencer one after another.

No sub-burst runs past the end of a memory page. No sub-burst is longer than the active burst cap. The cap is the tighter of a per-client limit and a per-device limit. Keeping each burst short bounds how long the memory chip-enable stays low (the device allows about 8 µs). It also bounds how long other clients wait, because a sub-burst cannot be interrupted once the sequencer has taken it.

Sub-bursts go out over a valid/ready handshake. The block waits for a completion pulse from the sequencer before it moves on. When the whole transfer is finished it raises a one-cycle completion carrying the client identity.

Top module: `burst_splitter`

## Requirements
- R1: While `rst` is high, and afterwards until a request is taken, `req_ready` is 1 and both `frag_valid` and `xfer_done` are 0.
- R2: For every offered sub-burst, (`frag_addr` mod PAGE_BYTES) + `frag_len` ≤ PAGE_BYTES. The default PAGE_BYTES is 1024.
- R3: The active cap is the smaller of two limits:
  - the client limit, `req_burst_max[16k+15:16k]` for k = `req_id`;
  - the device limit, `dev_burst_max[16d+15:16d]` for d = `frag_addr[27:24]` (that is, ADDR_W-1 down to ADDR_W-4), evaluated at each sub-burst.

  A limit value of 0 places no cap. `frag_len` never exceeds the active cap.
- R4: Each `frag_len` equals min(bytes still to move, active cap, bytes left in the current page). Sub-bursts follow each other at ascending, contiguous addresses, wrapping modulo 2^ADDR_W. Their lengths sum to the request length.
- R5: Only one sub-burst is outstanding at a time. `frag_valid` rises the cycle after a request is taken. After that, it rises again only in the cycle right after a `frag_done` pulse for a transfer that still has bytes left.
- R6: While `frag_valid` is 1 and `frag_ready` is 0, `frag_addr`, `frag_len` and `frag_id` stay unchanged.
- R7: `frag_id` carries the `req_id` of the transfer being cut up, and `xfer_id` carries the same value on completion.
- R8: `xfer_done` is a one-cycle pulse in the cycle after the `frag_done` that finishes the last sub-burst. `req_ready` is 1 again in that same cycle.
- R9: A request with `req_len` = 0 is taken and offers no sub-burst. `xfer_done` pulses with its `xfer_id` in the next cycle.
- R10: `req_ready` is 0 from the cycle after a non-empty request is taken until the completion cycle. Request inputs presented during that time have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken when valid |
| req_addr | input | ADDR_W (28) | Start byte address |
| req_len | input | LEN_W (16) | Byte count |
| req_id | input | ID_W (2) | Client identity |
| req_burst_max | input | NUM_REQ*16 (64) | Per-client burst limits, 0 = none |
| dev_burst_max | input | NUM_DEV*16 (256) | Per-device burst limits, 0 = none |
| frag_valid | output | 1 | Sub-burst offered |
| frag_ready | input | 1 | Sequencer takes the sub-burst |
| frag_addr | output | ADDR_W (28) | Sub-burst start address |
| frag_len | output | LEN_W (16) | Sub-burst byte count |
| frag_id | output | ID_W (2) | Client identity of the sub-burst |
| frag_done | input | 1 | Sequencer finished the taken sub-burst |
| xfer_done | output | 1 | Whole transfer finished (one cycle) |
| xfer_id | output | ID_W (2) | Client identity of the finished transfer |

## Verification
The timing of each result is fixed:
- `frag_valid` is due one cycle after the request handshake, and again one cycle after each non-final `frag_done`.
- `xfer_done` is due one cycle after the final `frag_done`, or one cycle after a zero-length request is taken.
- `frag_len` and `frag_addr` are valid in the same cycle as `frag_valid`.

The bench holds a behavioural model that advances at each falling edge, at the same moment it drives the next inputs. The outputs are compared at the following falling edge, after exactly one rising edge. This means every expected value lines up with the single register stage the block has between an input event and its result.

// File: rtl/bsplit_pkg.sv
package bsplit_pkg;

    // Width of one burst limit field.
    localparam int LIM_W = 16;

    typedef logic [LIM_W-1:0] lim_t;

    typedef enum logic [1:0] {
        BS_IDLE,
        BS_ISSUE,
        BS_WAIT
    } bs_state_e;

    // Tighter of two limits; a zero means "no cap" from that source.
    // The result is all-ones when neither source caps.
    function automatic lim_t tighter_limit(lim_t a, lim_t b);
        lim_t r;
        if (a == '0 && b == '0)      r = '1;
        else if (a == '0)            r = b;
        else if (b == '0)            r = a;
        else                         r = (a < b) ? a : b;
        return r;
    endfunction

endpackage

// File: rtl/bsplit_limit.sv
module bsplit_limit
    import bsplit_pkg::*;
#(
    parameter int NUM_REQ = 4,
    parameter int NUM_DEV = 16,
    parameter int ID_W    = 2,
    parameter int DEV_W   = 4
) (
    input  logic [NUM_REQ*LIM_W-1:0] req_max,
    input  logic [NUM_DEV*LIM_W-1:0] dev_max,
    input  logic [ID_W-1:0]          id,
    input  logic [DEV_W-1:0]         dev,
    output lim_t                     limit
);

    lim_t req_tab [NUM_REQ];
    lim_t dev_tab [NUM_DEV];

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
        assign req_tab[g] = req_max[g*LIM_W +: LIM_W];
    end

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
        assign dev_tab[g] = dev_max[g*LIM_W +: LIM_W];
    end

    assign limit = tighter_limit(req_tab[id], dev_tab[dev]);

endmodule

// File: rtl/bsplit_frag_calc.sv
module bsplit_frag_calc
    import bsplit_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int PAGE_BYTES = 1024,
    parameter int PAGE_W     = $clog2(PAGE_BYTES)
) (
    input  logic [PAGE_W-1:0] page_off,
    input  logic [LEN_W-1:0]  left,
    input  lim_t              limit,
    output logic [LEN_W-1:0]  frag_len
);

    localparam int CW = ((LEN_W > LIM_W) ? LEN_W : LIM_W) + 1;

    logic [CW-1:0] page_room;
    logic [CW-1:0] pick;

    always_comb begin
        page_room = CW'(PAGE_BYTES) - CW'(page_off);
        pick      = CW'(left);
        if (CW'(limit) < pick)  pick = CW'(limit);
        if (page_room < pick)   pick = page_room;
        frag_len  = LEN_W'(pick);
    end

endmodule

// File: rtl/burst_splitter.sv
module burst_splitter
    import bsplit_pkg::*;
#(
    parameter int ADDR_W     = 28,
    parameter int LEN_W      = 16,
    parameter int NUM_REQ    = 4,
    parameter int NUM_DEV    = 16,
    parameter int PAGE_BYTES = 1024,
    localparam int ID_W      = $clog2(NUM_REQ),
    localparam int DEV_W     = $clog2(NUM_DEV),
    localparam int PAGE_W    = $clog2(PAGE_BYTES)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [LEN_W-1:0]         req_len,
    input  logic [ID_W-1:0]          req_id,
    input  logic [NUM_REQ*LIM_W-1:0] req_burst_max,
    input  logic [NUM_DEV*LIM_W-1:0] dev_burst_max,
    output logic                     frag_valid,
    input  logic                     frag_ready,
    output logic [ADDR_W-1:0]        frag_addr,
    output logic [LEN_W-1:0]         frag_len,
    output logic [ID_W-1:0]          frag_id,
    input  logic                     frag_done,
    output logic                     xfer_done,
    output logic [ID_W-1:0]          xfer_id
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  left;
        logic [ID_W-1:0]   id;
    } job_t;

    bs_state_e        state;
    job_t             job_q;
    logic [LEN_W-1:0] issued_q;
    logic             done_q;
    logic [ID_W-1:0]  done_id_q;
    lim_t             lim_c;
    logic [LEN_W-1:0] cut_c;

    bsplit_limit #(
        .NUM_REQ (NUM_REQ),
        .NUM_DEV (NUM_DEV),
        .ID_W    (ID_W),
        .DEV_W   (DEV_W)
    ) u_limit (
        .req_max (req_burst_max),
        .dev_max (dev_burst_max),
        .id      (job_q.id),
        .dev     (job_q.addr[ADDR_W-1 -: DEV_W]),
        .limit   (lim_c)
    );

    bsplit_frag_calc #(
        .LEN_W      (LEN_W),
        .PAGE_BYTES (PAGE_BYTES),
        .PAGE_W     (PAGE_W)
    ) u_calc (
        .page_off (job_q.addr[PAGE_W-1:0]),
        .left     (job_q.left),
        .limit    (lim_c),
        .frag_len (cut_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= BS_IDLE;
            job_q     <= '0;
            issued_q  <= '0;
            done_q    <= 1'b0;
            done_id_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                BS_IDLE: begin
                    if (req_valid) begin
                        job_q <= '{addr: req_addr, left: req_len, id: req_id};
                        if (req_len == '0) begin
                            done_q    <= 1'b1;
                            done_id_q <= req_id;
                        end else begin
                            state <= BS_ISSUE;
                        end
                    end
                end
                BS_ISSUE: begin
                    if (frag_ready) begin
                        issued_q <= cut_c;
                        state    <= BS_WAIT;
                    end
                end
                BS_WAIT: begin
                    if (frag_done) begin
                        job_q.addr <= job_q.addr + ADDR_W'(issued_q);
                        job_q.left <= job_q.left - issued_q;
                        if (job_q.left == issued_q) begin
                            done_q    <= 1'b1;
                            done_id_q <= job_q.id;
                            state     <= BS_IDLE;
                        end else begin
                            state <= BS_ISSUE;
                        end
                    end
                end
                default: state <= BS_IDLE;
            endcase
        end
    end

    assign req_ready  = (state == BS_IDLE);
    assign frag_valid = (state == BS_ISSUE);
    assign frag_addr  = job_q.addr;
    assign frag_len   = cut_c;
    assign frag_id    = job_q.id;
    assign xfer_done  = done_q;
    assign xfer_id    = done_id_q;

    // Assertions
    AST_PAGE_SAFE: assert property (@(posedge clk) disable iff (rst)
        frag_valid |-> (int'(frag_addr[PAGE_W-1:0]) + int'(frag_len)) <= PAGE_BYTES); // R2

    AST_CAP_RESPECTED: assert property (@(posedge clk) disable iff (rst)
        frag_valid |-> int'(frag_len) <= int'(lim_c)); // R3

    AST_FRAG_NONZERO: assert property (@(posedge clk) disable iff (rst)
        frag_valid |-> (frag_len != '0) && (frag_len <= job_q.left)); // R4

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        (state == BS_WAIT && !frag_done) |=> !frag_valid); // R5

    AST_FRAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (frag_valid && !frag_ready) |=> frag_valid && $stable(frag_addr)
            && $stable(frag_len) && $stable(frag_id)); // R6

    AST_LAST_DONE: assert property (@(posedge clk) disable iff (rst)
        (state == BS_WAIT && frag_done && job_q.left == issued_q)
            |=> xfer_done && req_ready && (xfer_id == $past(job_q.id))); // R8

    AST_ZERO_LEN: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_len == '0) |=> xfer_done && !frag_valid); // R9

endmodule

// File: tb/burst_splitter_tb_top.sv
`timescale 1ns/1ps
module burst_splitter_tb_top;

    localparam int NR = 4;
    localparam int ND = 16;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 req_valid = 1'b0;
    logic                 req_ready;
    logic [27:0]          req_addr = '0;
    logic [15:0]          req_len = '0;
    logic [1:0]           req_id = '0;
    logic [NR*16-1:0]     req_burst_max = '0;
    logic [ND*16-1:0]     dev_burst_max = '0;
    logic                 frag_valid;
    logic                 frag_ready = 1'b0;
    logic [27:0]          frag_addr;
    logic [15:0]          frag_len;
    logic [1:0]           frag_id;
    logic                 frag_done = 1'b0;
    logic                 xfer_done;
    logic [1:0]           xfer_id;

    always #10 clk = ~clk;

    burst_splitter dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_id(req_id),
        .req_burst_max(req_burst_max), .dev_burst_max(dev_burst_max),
        .frag_valid(frag_valid), .frag_ready(frag_ready),
        .frag_addr(frag_addr), .frag_len(frag_len), .frag_id(frag_id),
        .frag_done(frag_done), .xfer_done(xfer_done), .xfer_id(xfer_id)
    );

    int checks = 0;
    int errors = 0;
    bit [31:0] seed = 32'h1234_5678;

    typedef struct { int addr; int len; int id; } rq_t;
    rq_t pend[$];
    int  ef_addr[$];
    int  ef_len[$];
    int  ef_lim[$];

    // Behavioural model: 0 idle, 1 offering, 2 waiting for done.
    int m_mode = 0;
    int m_id = 0;
    int m_did = 0;
    int m_wd = 0;
    bit m_done = 0;
    bit m_zero = 0;
    bit m_hold = 0;

    function automatic int unsigned rnd();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic plan_frags(input int addr, input int len, input int id);
        int a = addr;
        int r = len;
        while (r > 0) begin
            int rl = int'(req_burst_max[id*16 +: 16]);
            int dl = int'(dev_burst_max[((a >> 24) & 15)*16 +: 16]);
            int lim = 1 << 30;
            int pg = 1024 - (a % 1024);
            int n = r;
            if (rl != 0 && rl < lim) lim = rl;
            if (dl != 0 && dl < lim) lim = dl;
            if (lim < n) n = lim;
            if (pg < n) n = pg;
            ef_addr.push_back(a);
            ef_len.push_back(n);
            ef_lim.push_back(lim);
            a = (a + n) & 32'h0FFF_FFFF;
            r -= n;
        end
    endtask

    task automatic step();
        int unsigned x;
        @(negedge clk);
        // compare outputs with the model state after the last rising edge
        chk(req_ready === (m_mode == 0), "R10 req_ready", req_ready, m_mode == 0);
        chk(frag_valid === (m_mode == 1), "R5 frag_valid", frag_valid, m_mode == 1);
        chk(xfer_done === m_done, m_zero ? "R9 xfer_done" : "R8 xfer_done", xfer_done, m_done);
        if (m_done) chk(int'(xfer_id) == m_did, "R7 xfer_id", xfer_id, m_did);
        if (m_mode == 1 && frag_valid === 1'b1 && ef_len.size() > 0) begin
            chk(int'(frag_addr) == ef_addr[0], "R4 frag_addr", frag_addr, ef_addr[0]);
            chk(int'(frag_len) == ef_len[0], m_hold ? "R6 frag_len held" : "R4 frag_len",
                frag_len, ef_len[0]);
            chk(int'(frag_len) <= ef_lim[0], "R3 cap", frag_len, ef_lim[0]);
            chk((int'(frag_addr) % 1024) + int'(frag_len) <= 1024, "R2 page",
                (int'(frag_addr) % 1024) + int'(frag_len), 1024);
            chk(int'(frag_id) == m_id, "R7 frag_id", frag_id, m_id);
        end
        // drive next inputs and advance the model to the next rising edge
        m_done = 0;
        m_zero = 0;
        frag_ready = 1'b0;
        frag_done = 1'b0;
        req_valid = 1'b0;
        x = rnd();
        req_addr = 28'(rnd());
        req_len = 16'(rnd());
        req_id = 2'(x >> 8);
        case (m_mode)
            0: begin
                m_hold = 0;
                if (pend.size() > 0 && (x % 4) != 0) begin
                    rq_t q = pend.pop_front();
                    req_valid = 1'b1;
                    req_addr = 28'(q.addr);
                    req_len = 16'(q.len);
                    req_id = 2'(q.id);
                    if (q.len == 0) begin
                        m_done = 1;
                        m_zero = 1;
                        m_did = q.id;
                    end else begin
                        plan_frags(q.addr, q.len, q.id);
                        m_id = q.id;
                        m_mode = 1;
                    end
                end
            end
            1: begin
                req_valid = x[3];  // R10: ignored while busy
                frag_ready = ((x >> 4) % 3) != 0;
                m_hold = !frag_ready;
                if (frag_ready) begin
                    m_mode = 2;
                    m_wd = int'((x >> 10) % 3);
                end
            end
            default: begin
                req_valid = x[3];
                m_hold = 0;
                if (m_wd == 0) begin
                    frag_done = 1'b1;
                    void'(ef_addr.pop_front());
                    void'(ef_len.pop_front());
                    void'(ef_lim.pop_front());
                    if (ef_len.size() == 0) begin
                        m_mode = 0;
                        m_done = 1;
                        m_did = m_id;
                    end else begin
                        m_mode = 1;
                    end
                end else begin
                    m_wd--;
                end
            end
        endcase
    endtask

    task automatic drain();
        while (pend.size() > 0 || m_mode != 0) step();
        step();
        step();
    endtask

    task automatic add(input int addr, input int len, input int id);
        rq_t q;
        q.addr = addr;
        q.len = len;
        q.id = id;
        pend.push_back(q);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready === 1'b1, "R1 req_ready in reset", req_ready, 1);
        chk(frag_valid === 1'b0, "R1 frag_valid in reset", frag_valid, 0);
        chk(xfer_done === 1'b0, "R1 xfer_done in reset", xfer_done, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready === 1'b1 && frag_valid === 1'b0 && xfer_done === 1'b0,
            "R1 idle after reset", {req_ready, frag_valid, xfer_done}, 3'b100);

        // no caps: page cuts only (R2, R4), single byte, zero length (R9)
        add(32'h100, 2000, 1);
        add(32'h3FF, 1, 2);
        add(0, 0, 3);
        add(32'h0000_0800, 0, 0);
        add(32'h0000_0000, 65535, 0);
        drain();

        // client cap tighter for id 0, device cap tighter for id 1 (R3)
        req_burst_max[0*16 +: 16] = 16'd100;
        req_burst_max[2*16 +: 16] = 16'd700;
        dev_burst_max[0*16 +: 16] = 16'd300;
        add(32'h10, 500, 0);
        add(32'h10, 900, 1);
        add(32'h3F0, 900, 2);
        drain();

        // crossing into device 1 with a different cap
        req_burst_max = '0;
        dev_burst_max = '0;
        dev_burst_max[1*16 +: 16] = 16'd64;
        add(32'h0FF_FF00, 32'h300, 3);
        // wrap past the top of the address space into device 0
        dev_burst_max[15*16 +: 16] = 16'd8;
        add(32'h0FFF_FFF0, 32, 2);
        drain();

        // varied traffic under changing caps
        for (int ph = 0; ph < 6; ph++) begin
            for (int k = 0; k < NR; k++) req_burst_max[k*16 +: 16] = 16'(rnd() % 600);
            for (int k = 0; k < ND; k++) dev_burst_max[k*16 +: 16] = 16'(rnd() % 900);
            for (int k = 0; k < 6; k++)
                add(int'(rnd() & 32'h0FFF_FFFF), int'(rnd() % 3000), int'(rnd() % 4));
            drain();
        end

        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        summary();
        $finish;
    end

endmodule